// File: doc/BRIEF.md
# Descriptor Decode and Execute Engine

This block accepts one 128-bit descriptor at a time, made of two 64-bit words, from an upstream ring controller. It decodes a 4-bit type code and carries the descriptor out over a simple line-granular memory port. A copy descriptor moves a run of 64-byte lines from a source to a destination, one line read followed by one line write. A status descriptor stores a single 64-bit word into one 8-byte lane of a line and may raise an interrupt once that store completes.

The engine has no queue. The controller offers a descriptor while `desc_ready` is high, and the engine reports completion with a one-cycle `done` pulse. `err` and `irq` qualify that pulse. The memory port carries line addresses, which are byte addresses shifted right by 6. Every request stays asserted until the memory acknowledges it.

Top module: `dma_desc_exec`

## Requirements
- R1: The type code is `desc_w1[63:60]`. Code 1 selects a copy and code 2 selects a status store. No other field of the descriptor changes which kind is chosen.
- R2: For a copy, the source byte address is `desc_w0[ADDR_W-1:0]`, the destination byte address is `desc_w1[ADDR_W-1:0]`, and the line count is `desc_w0[63:46]`. The engine issues, in order, a read of source line i and then a full-mask write of the data just read to destination line i, for i = 0 up to count-1.
- R3: A copy whose line count is zero issues no memory request. `done` is high in the cycle after the descriptor is accepted.
- R4: A descriptor with any type code other than 1 or 2 issues no memory request. `done` and `err` are high together in the cycle after it is accepted.
- R5: A status descriptor issues exactly one write, to line `desc_w1[ADDR_W-1:6]`. `mem_wdata` carries `desc_w0` in every 64-bit lane. `mem_wmask` holds eight ones at bits lane*8 to lane*8+7, where lane = `desc_w1[5:3]`, and zeros elsewhere.
- R6: `irq` is high only together with `done`, and only for a status descriptor whose `desc_w1[59]` is 1. Bit 59 of a copy descriptor is ignored.
- R7: `done` is a one-cycle pulse, high in the cycle after the final memory acknowledge. `desc_ready` is high only while the engine is idle and is never high in the `done` cycle.
- R8: While `mem_req` is high and `mem_ack` is low, the request, address, write enable and mask hold their values in the next cycle.
- R9: After reset, `desc_ready` is 1 and `mem_req`, `done`, `irq` and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| desc_valid | input | 1 | A descriptor is offered |
| desc_ready | output | 1 | Engine is idle and takes the offered descriptor |
| desc_w0 | input | 64 | First descriptor word |
| desc_w1 | input | 64 | Second descriptor word |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W-6 | Line address |
| mem_wdata | output | 512 | Write line data |
| mem_wmask | output | 64 | Byte write enables |
| mem_rdata | input | 512 | Read line data, valid with `mem_ack` on a read |
| mem_ack | input | 1 | One-cycle acknowledge of the current request |
| done | output | 1 | Descriptor retired |
| irq | output | 1 | Interrupt request for a status store |
| err | output | 1 | Retired descriptor had an unknown type |

## Verification
The assertions assume three things about the inputs. `mem_ack` arrives only while `mem_req` is high, and lasts one cycle per request. `mem_rdata` is meaningful in the acknowledge cycle of a read. The descriptor words are stable while `desc_valid` is offered. The bench memory responder acknowledges only a request it sees, with a random delay, and drops the acknowledge on the following cycle. Copy lengths stay small and addresses are line-aligned random values, so every access fits in the bench log.

// File: rtl/dma_exec_pkg.sv
// Shared constants and types for the descriptor engine.
// Assumes the fixed two-word descriptor layout; only address width varies.
package dma_exec_pkg;
    localparam int WORD_W   = 64;
    localparam int TYPE_HI  = 63;
    localparam int TYPE_LO  = 60;
    localparam int IRQ_BIT  = 59;
    localparam int CNT_HI   = 63;
    localparam int CNT_LO   = 46;
    localparam int CNT_W    = CNT_HI - CNT_LO + 1;
    localparam logic [3:0] CODE_COPY   = 4'd1;
    localparam logic [3:0] CODE_STATUS = 4'd2;

    typedef enum logic [1:0] {
        KIND_COPY,
        KIND_EMPTY,
        KIND_STATUS,
        KIND_BAD
    } desc_kind_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_READ,
        S_WRITE,
        S_STORE,
        S_RETIRE
    } exec_state_t;
endpackage

// File: rtl/dma_desc_decode.sv
// Combinational descriptor field extraction and classification.
// Assumes the 64-byte line size fixed by the descriptor format.
module dma_desc_decode
    import dma_exec_pkg::*;
#(
    parameter int ADDR_W = 40,
    parameter int OFF_W  = 6
) (
    input  logic [WORD_W-1:0]        w0,
    input  logic [WORD_W-1:0]        w1,
    output desc_kind_t               kind,
    output logic [ADDR_W-OFF_W-1:0]  src_line,
    output logic [ADDR_W-OFF_W-1:0]  dst_line,
    output logic [CNT_W-1:0]         line_cnt,
    output logic [WORD_W-1:0]        stat_data,
    output logic [OFF_W-4:0]         stat_lane,
    output logic                     want_irq
);
    logic [3:0] code;
    logic       unused_bits;

    assign code      = w1[TYPE_HI:TYPE_LO];
    assign src_line  = w0[ADDR_W-1:OFF_W];
    assign dst_line  = w1[ADDR_W-1:OFF_W];
    assign line_cnt  = w0[CNT_HI:CNT_LO];
    assign stat_data = w0;
    assign stat_lane = w1[OFF_W-1:3];
    assign want_irq  = w1[IRQ_BIT];
    assign unused_bits = ^{w1[IRQ_BIT-1:ADDR_W], w1[2:0]};

    // classify the descriptor from its type code and length
    always_comb begin
        if (code == CODE_COPY)
            kind = (line_cnt == '0) ? KIND_EMPTY : KIND_COPY;
        else if (code == CODE_STATUS)
            kind = KIND_STATUS;
        else
            kind = KIND_BAD;
    end
endmodule

// File: rtl/dma_line_cursor.sv
// Source/destination line pointers and remaining-line counter for a copy.
// Assumes step is asserted only while at least one line remains.
module dma_line_cursor #(
    parameter int LINE_AW = 34,
    parameter int CNT_W   = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [LINE_AW-1:0] src_init,
    input  logic [LINE_AW-1:0] dst_init,
    input  logic [CNT_W-1:0]   cnt_init,
    input  logic               step,
    output logic [LINE_AW-1:0] src_line,
    output logic [LINE_AW-1:0] dst_line,
    output logic               last
);
    logic [CNT_W-1:0] remain;

    assign last = (remain == CNT_W'(1));

    // load a new run or advance both pointers after each written line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_line <= '0;
            dst_line <= '0;
            remain   <= '0;
        end else if (load) begin
            src_line <= src_init;
            dst_line <= dst_init;
            remain   <= cnt_init;
        end else if (step) begin
            src_line <= src_line + LINE_AW'(1);
            dst_line <= dst_line + LINE_AW'(1);
            remain   <= remain - CNT_W'(1);
        end
    end

    // R2
    no_step_past_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (remain != '0));
    // R2
    step_advances_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (src_line == $past(src_line) + LINE_AW'(1)));
endmodule

// File: rtl/dma_desc_exec.sv
// Descriptor execution engine: accepts one descriptor, runs line copies
// or a masked status store over a line memory port, then pulses done.
// Assumes mem_ack is a one-cycle reply to the request currently held.
module dma_desc_exec
    import dma_exec_pkg::*;
#(
    parameter int ADDR_W     = 40,
    parameter int LINE_BYTES = 64
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               desc_valid,
    output logic                               desc_ready,
    input  logic [63:0]                        desc_w0,
    input  logic [63:0]                        desc_w1,
    output logic                               mem_req,
    output logic                               mem_we,
    output logic [ADDR_W-$clog2(LINE_BYTES)-1:0] mem_addr,
    output logic [LINE_BYTES*8-1:0]            mem_wdata,
    output logic [LINE_BYTES-1:0]              mem_wmask,
    input  logic [LINE_BYTES*8-1:0]            mem_rdata,
    input  logic                               mem_ack,
    output logic                               done,
    output logic                               irq,
    output logic                               err
);
    localparam int OFF_W   = $clog2(LINE_BYTES);
    localparam int LINE_AW = ADDR_W - OFF_W;
    localparam int LINE_W  = LINE_BYTES * 8;
    localparam int LANES   = LINE_BYTES / 8;
    localparam int LANE_W  = $clog2(LANES);

    exec_state_t          state;
    desc_kind_t           dec_kind;
    logic [LINE_AW-1:0]   dec_src, dec_dst, cur_src, cur_dst;
    logic [CNT_W-1:0]     dec_cnt;
    logic [WORD_W-1:0]    dec_data;
    logic [LANE_W-1:0]    dec_lane;
    logic                 dec_irq;
    logic                 accept, cur_last, cur_step;
    logic [LINE_W-1:0]    line_buf;
    logic [WORD_W-1:0]    st_data_q;
    logic [LINE_AW-1:0]   st_line_q;
    logic [LANE_W-1:0]    st_lane_q;
    logic                 irq_q, bad_q;
    logic [LINE_BYTES-1:0] lane_mask;

    dma_desc_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_decode (
        .w0(desc_w0), .w1(desc_w1), .kind(dec_kind),
        .src_line(dec_src), .dst_line(dec_dst), .line_cnt(dec_cnt),
        .stat_data(dec_data), .stat_lane(dec_lane), .want_irq(dec_irq)
    );

    assign accept   = desc_valid && desc_ready;
    assign cur_step = (state == S_WRITE) && mem_ack;

    dma_line_cursor #(.LINE_AW(LINE_AW), .CNT_W(CNT_W)) u_cursor (
        .clk(clk), .rst_n(rst_n),
        .load(accept && (dec_kind == KIND_COPY)),
        .src_init(dec_src), .dst_init(dec_dst), .cnt_init(dec_cnt),
        .step(cur_step), .src_line(cur_src), .dst_line(cur_dst),
        .last(cur_last)
    );

    // byte enables for the selected 8-byte lane of a status store
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_mask[g*8 +: 8] = {8{st_lane_q == LANE_W'(g)}};
    end

    // sequence the descriptor through read/write/store and retirement
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            case (state)
                S_IDLE:
                    if (accept) begin
                        case (dec_kind)
                            KIND_COPY:   state <= S_READ;
                            KIND_STATUS: state <= S_STORE;
                            default:     state <= S_RETIRE;
                        endcase
                    end
                S_READ:   if (mem_ack) state <= S_WRITE;
                S_WRITE:  if (mem_ack) state <= cur_last ? S_RETIRE : S_READ;
                S_STORE:  if (mem_ack) state <= S_RETIRE;
                default:  state <= S_IDLE;
            endcase
        end
    end

    // latch per-descriptor status fields and retirement flags at accept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_data_q <= '0;
            st_line_q <= '0;
            st_lane_q <= '0;
            irq_q     <= 1'b0;
            bad_q     <= 1'b0;
        end else if (accept) begin
            st_data_q <= dec_data;
            st_line_q <= dec_dst;
            st_lane_q <= dec_lane;
            irq_q     <= (dec_kind == KIND_STATUS) && dec_irq;
            bad_q     <= (dec_kind == KIND_BAD);
        end
    end

    // hold the line returned by the last read for the following write
    always_ff @(posedge clk) begin
        if (!rst_n)
            line_buf <= '0;
        else if ((state == S_READ) && mem_ack)
            line_buf <= mem_rdata;
    end

    // drive the memory port and completion outputs from the state
    always_comb begin
        desc_ready = (state == S_IDLE);
        mem_req    = (state == S_READ) || (state == S_WRITE) || (state == S_STORE);
        mem_we     = (state == S_WRITE) || (state == S_STORE);
        mem_addr   = '0;
        mem_wdata  = line_buf;
        mem_wmask  = '0;
        case (state)
            S_READ:  mem_addr = cur_src;
            S_WRITE: begin
                mem_addr  = cur_dst;
                mem_wmask = '1;
            end
            S_STORE: begin
                mem_addr  = st_line_q;
                mem_wdata = {LANES{st_data_q}};
                mem_wmask = lane_mask;
            end
            default: ;
        endcase
        done = (state == S_RETIRE);
        irq  = done && irq_q;
        err  = done && bad_q;
    end

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wmask)));
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!desc_ready && !mem_req));
    // R6
    irq_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done);
    // R4
    err_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (done && !irq));
    // R3
    empty_copy_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && desc_w1[63:60] == CODE_COPY && desc_w0[63:46] == '0)
        |=> (done && !mem_req && !err));
    // R4
    bad_type_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && desc_w1[63:60] != CODE_COPY && desc_w1[63:60] != CODE_STATUS)
        |=> (done && err && !mem_req));
endmodule

// File: tb/test_dma_desc_exec.sv
`timescale 1ns/1ps
module test_dma_desc_exec;
    localparam int ADDR_W  = 40;
    localparam int LB      = 64;
    localparam int LINE_AW = ADDR_W - 6;
    localparam int LINE_W  = LB * 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic desc_valid = 1'b0;
    logic desc_ready;
    logic [63:0] desc_w0 = '0, desc_w1 = '0;
    logic mem_req, mem_we;
    logic [LINE_AW-1:0] mem_addr;
    logic [LINE_W-1:0] mem_wdata, mem_rdata = '0;
    logic [LB-1:0] mem_wmask;
    logic mem_ack = 1'b0;
    logic done, irq, err;

    dma_desc_exec #(.ADDR_W(ADDR_W), .LINE_BYTES(LB)) i_dma_desc_exec (
        .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_w0(desc_w0), .desc_w1(desc_w1), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wmask(mem_wmask),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .done(done), .irq(irq), .err(err)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_err = 0;
    bit finished = 0;
    int cyc = 0, last_ack_cyc = 0, done_cyc = 0, done_cnt = 0, stray = 0;
    bit irq_seen = 0, err_seen = 0;
    logic               lg_we[64];
    logic [LINE_AW-1:0] lg_addr[64];
    logic [LINE_W-1:0]  lg_data[64];
    logic [LB-1:0]      lg_mask[64];
    int lg_n = 0;

    function automatic logic [LINE_W-1:0] rd_line(input logic [LINE_AW-1:0] a);
        logic [LINE_W-1:0] r;
        for (int j = 0; j < LB/8; j++)
            r[j*64 +: 64] = {a[31:0] ^ 32'h3C5A_0F00, 22'h0, a[33:32], 8'(j)};
        return r;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // memory responder and output monitor, active on falling edges
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            mem_ack = 1'b0;
            if (rst_n && mem_req && ($urandom % 3 != 0)) begin
                mem_ack = 1'b1;
                if (!mem_we) mem_rdata = rd_line(mem_addr);
                if (lg_n < 64) begin
                    lg_we[lg_n] = mem_we;
                    lg_addr[lg_n] = mem_addr;
                    lg_data[lg_n] = mem_we ? mem_wdata : rd_line(mem_addr);
                    lg_mask[lg_n] = mem_wmask;
                end
                lg_n++;
                last_ack_cyc = cyc;
            end
            if (rst_n && done) begin
                done_cnt++;
                done_cyc = cyc;
                irq_seen = irq;
                err_seen = err;
            end
            if (rst_n && !done && (irq || err)) stray++;
        end
    end

    task automatic run_desc(input logic [63:0] w0, input logic [63:0] w1);
        logic [3:0] code = w1[63:60];
        int acc_cyc, n, tmo;
        logic [LINE_AW-1:0] s, d;
        tmo = 0;
        while (!desc_ready && tmo < 100) begin @(posedge clk); #1; tmo++; end
        lg_n = 0; done_cnt = 0;
        desc_w0 = w0; desc_w1 = w1; desc_valid = 1'b1;
        @(posedge clk); #1;
        desc_valid = 1'b0;
        acc_cyc = cyc;
        tmo = 0;
        while (done_cnt == 0 && tmo < 300) begin @(posedge clk); #1; tmo++; end
        repeat (2) @(posedge clk);
        #1;
        chk("R7", "single done pulse", done_cnt, 1);
        chk("R6", "irq with done", irq_seen,
            (code == 4'd2) ? w1[59] : 1'b0);
        chk("R4", "err with done", err_seen, (code != 4'd1 && code != 4'd2));
        if (code == 4'd1) begin
            n = int'(w0[63:46]);
            s = w0[ADDR_W-1:6]; d = w1[ADDR_W-1:6];
            if (n == 0) begin
                chk("R3", "empty copy accesses", lg_n, 0);
                chk("R3", "empty copy done cycle", done_cyc, acc_cyc + 1);
            end else begin
                chk("R2", "copy access count", lg_n, 2*n);
                for (int i = 0; i < n && 2*i+1 < 64; i++) begin
                    chk("R2", "read kind", lg_we[2*i], 1'b0);
                    chk("R2", "read addr", lg_addr[2*i], s + LINE_AW'(i));
                    chk("R2", "write kind", lg_we[2*i+1], 1'b1);
                    chk("R2", "write addr", lg_addr[2*i+1], d + LINE_AW'(i));
                    chk("R2", "write data", lg_data[2*i+1], rd_line(s + LINE_AW'(i)));
                    chk("R2", "write mask", lg_mask[2*i+1], {LB{1'b1}});
                end
                chk("R7", "copy done after last ack", done_cyc, last_ack_cyc + 1);
            end
        end else if (code == 4'd2) begin
            chk("R5", "status access count", lg_n, 1);
            chk("R5", "status is write", lg_we[0], 1'b1);
            chk("R5", "status addr", lg_addr[0], w1[ADDR_W-1:6]);
            chk("R5", "status data", lg_data[0], {(LB/8){w0}});
            chk("R5", "status mask", lg_mask[0], {{(LB-8){1'b0}}, 8'hFF} << (int'(w1[5:3]) * 8));
            chk("R7", "status done after ack", done_cyc, last_ack_cyc + 1);
        end else begin
            chk("R4", "bad type accesses", lg_n, 0);
            chk("R4", "bad type done cycle", done_cyc, acc_cyc + 1);
        end
    endtask

    function automatic logic [63:0] mk_copy(input logic [39:0] a, input int n);
        return {18'(n), 6'h0, a[39:6], 6'h0};
    endfunction

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED);
        repeat (4) @(posedge clk);
        #1;
        chk("R9", "ready in reset", desc_ready, 1'b1);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R9", "ready after reset", desc_ready, 1'b1);
        chk("R9", "no req after reset", mem_req, 1'b0);
        chk("R9", "no done/irq/err after reset", {done, irq, err}, 3'b000);

        // directed: R1 R2 copies, one with bit 59 set (R6 ignored on copy)
        run_desc(mk_copy(40'h12_3456_7840, 1), {4'd1, 20'h0, 40'hAB_CDEF_0000});
        run_desc(mk_copy(40'h00_0000_1000, 3), {4'd1, 1'b1, 19'h0, 40'h55_0000_2040});
        // R3 zero-length copy
        run_desc(mk_copy(40'h00_0000_4000, 0), {4'd1, 20'h0, 40'h00_0000_8000});
        // R4 unknown types
        run_desc(64'h0, 64'h0);
        run_desc(64'hFFFF_FFFF_FFFF_FFFF, {4'd3, 60'h0});
        run_desc(mk_copy(40'h40, 2), {4'hF, 1'b1, 59'h0});
        // R5 R6 status, lane 0 with irq, lane 7 without
        run_desc(64'hDEAD_BEEF_0123_4567, {4'd2, 1'b1, 19'h0, 40'h01_0000_0040});
        run_desc(64'h1111_2222_3333_4444, {4'd2, 1'b0, 19'h0, 40'h02_0000_0078});
        run_desc(64'hCAFE_F00D_0000_0001, {4'd2, 1'b1, 19'h0, 40'h03_0000_0090});

        // random mix
        for (int k = 0; k < 40; k++) begin
            int r = $urandom % 8;
            logic [63:0] w0, w1;
            logic [39:0] a = {$urandom, $urandom};
            logic [39:0] b = {$urandom, $urandom};
            if (r < 4) begin
                w0 = mk_copy(a, $urandom % 6);
                w1 = {4'd1, 1'($urandom), 19'h0, b[39:6], 6'h0};
            end else if (r < 6) begin
                w0 = {$urandom, $urandom};
                w1 = {4'd2, 1'($urandom), 19'h0, b[39:3], 3'h0};
            end else begin
                logic [3:0] t = 4'(3 + $urandom % 13);
                w0 = {$urandom, $urandom};
                w1 = {t, 20'h0, b};
            end
            run_desc(w0, w1);
        end
        chk("R6", "irq/err never without done", stray, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule